// File: doc/BRIEF.md
# Dual Chip-Select Memory Window Decoder

This block sits between an on-chip request path and a memory controller that drives two SDRAM devices. It takes a 30-bit byte address inside a 1 GB window and decides, one cycle later, whether the address belongs to device 0, to device 1, or to no device. When a device is selected, it also returns the byte offset inside that device. Addresses that no device covers are flagged as errors and are never folded back onto a device.

Device 0 always begins at address zero. Device 1 begins at a programmable base formed from a coarse index that counts 128 MB steps and a fine index that counts 32 MB steps. The extent of each device is a 10-bit size code in 2 MB units, and a zero code switches that device off. A small write port loads the three configuration registers. Two status outputs report a device 1 base that is not aligned to its size (sticky until reset) and an overlap between the two devices.

Top module: `csdec_decoder`

## Requirements
- R1: After reset `rsp_valid`, `cfg_err` and `overlap` are 0, device 0 has size code 0x010 (32 MB), device 1 has size code 0 and both base fields are 0.
- R2: `rsp_valid` equals the `req_valid` of the previous cycle; while `rsp_valid` is 0, `rsp_cs`, `rsp_err` and `rsp_offset` are all 0.
- R3: A request with address below size0 × 2 MB (size0 nonzero) answers `rsp_cs` = 2'b01, `rsp_err` = 0 and `rsp_offset` equal to the address.
- R4: Device 1 covers [base, base + size1 × 2 MB) with base = coarse × 128 MB + fine × 32 MB; a request inside it that device 0 does not claim answers `rsp_cs` = 2'b10 and `rsp_offset` = address − base.
- R5: A request that no enabled device claims answers `rsp_err` = 1, `rsp_cs` = 0 and `rsp_offset` = 0.
- R6: A size code of 0 disables that device: no request ever selects it.
- R7: Where both devices cover an address, device 0 is selected; `overlap` is 1 in the cycle after the configuration makes both devices enabled with base < size0 × 2 MB, and 0 otherwise.
- R8: Device 1 is misaligned when it is enabled and its base is not a multiple of its size rounded up to a power of two; this sets `cfg_err`, which stays 1 until reset, and while the misalignment exists or `cfg_err` is 1 every request that only device 1 would claim answers with an error.
- R9: A write with `cfg_we` = 1 uses `cfg_idx` 0 for the device 0 size code, 1 for the device 1 size code and 2 for the base, with fine = `cfg_wdata[1:0]` and coarse = `cfg_wdata[5:2]`; index 3 changes nothing; a request in the cycle after the write is decoded with the new value.
- R10: `rsp_cs` has at most one bit set, and during a response exactly one of `rsp_err` and a nonzero `rsp_cs` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration register index |
| cfg_wdata | input | 10 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 30 | Request byte address |
| rsp_valid | output | 1 | Response present |
| rsp_cs | output | 2 | One-hot selected device |
| rsp_err | output | 1 | Address not covered by a usable device |
| rsp_offset | output | 30 | Byte offset inside the selected device |
| cfg_err | output | 1 | Sticky device 1 misalignment status |
| overlap | output | 1 | Device regions overlap |

## Verification
On every cycle the assertions hold the response timing, the all-zero idle response, the one-hot select with its exclusivity against the error flag, the stickiness of the alignment status, the rule that no device 1 response appears while that status is set, and the offset of device 0 equalling the previous address. Whether a given address lands on the right device with the right offset, whether region boundaries sit where the size and base codes say, how overlap resolves, and whether a write takes effect in the next cycle depend on the programmed configuration, so only the bench's address sweeps over several configurations can show them, compared against an arithmetic model.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    // Configuration register index encoding
    typedef enum logic [1:0] {
        CFG_SIZE0 = 2'd0,
        CFG_SIZE1 = 2'd1,
        CFG_BASE1 = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_idx_e;

    localparam int unsigned DEF_ADDR_W     = 30;
    localparam int unsigned DEF_SIZE_W     = 10;
    localparam int unsigned DEF_UNIT_LG2   = 21;  // 2 MB size unit
    localparam int unsigned DEF_COARSE_W   = 4;
    localparam int unsigned DEF_COARSE_LG2 = 27;  // 128 MB step
    localparam int unsigned DEF_FINE_W     = 2;
    localparam int unsigned DEF_FINE_LG2   = 25;  // 32 MB step

endpackage

// File: rtl/csdec_cfg_regs.sv
module csdec_cfg_regs
    import csdec_pkg::*;
#(
    parameter int unsigned SIZE_W   = DEF_SIZE_W,
    parameter int unsigned COARSE_W = DEF_COARSE_W,
    parameter int unsigned FINE_W   = DEF_FINE_W,
    parameter logic [SIZE_W-1:0] SIZE0_RST = 10'h010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          idx,
    input  logic [SIZE_W-1:0]   wdata,
    output logic [SIZE_W-1:0]   size0,
    output logic [SIZE_W-1:0]   size1,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine
);

    typedef struct packed {
        logic [SIZE_W-1:0]   size0;
        logic [SIZE_W-1:0]   size1;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_idx_e'(idx))
                CFG_SIZE0: cfg_d.size0 = wdata;
                CFG_SIZE1: cfg_d.size1 = wdata;
                CFG_BASE1: begin
                    cfg_d.fine   = wdata[FINE_W-1:0];
                    cfg_d.coarse = wdata[FINE_W +: COARSE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.size0  <= SIZE0_RST;
            cfg_q.size1  <= '0;
            cfg_q.coarse <= '0;
            cfg_q.fine   <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign size0  = cfg_q.size0;
    assign size1  = cfg_q.size1;
    assign coarse = cfg_q.coarse;
    assign fine   = cfg_q.fine;

endmodule

// File: rtl/csdec_region_match.sv
module csdec_region_match
    import csdec_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned EXT_W    = DEF_ADDR_W + 3,
    parameter int unsigned SIZE_W   = DEF_SIZE_W,
    parameter int unsigned UNIT_LG2 = DEF_UNIT_LG2
) (
    input  logic [EXT_W-1:0]  start,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [EXT_W-1:0] addr_ext;
    logic [EXT_W-1:0] size_bytes;
    logic [EXT_W-1:0] end_bytes;
    logic [EXT_W-1:0] diff;

    always_comb begin
        addr_ext   = EXT_W'(addr);
        size_bytes = EXT_W'(size_code) << UNIT_LG2;
        end_bytes  = start + size_bytes;
        diff       = addr_ext - start;
        hit        = (size_code != '0) && (addr_ext >= start) && (addr_ext < end_bytes);
        offset     = diff[ADDR_W-1:0];
    end

endmodule

// File: rtl/csdec_align_check.sv
module csdec_align_check
    import csdec_pkg::*;
#(
    parameter int unsigned EXT_W    = DEF_ADDR_W + 3,
    parameter int unsigned SIZE_W   = DEF_SIZE_W,
    parameter int unsigned UNIT_LG2 = DEF_UNIT_LG2
) (
    input  logic [EXT_W-1:0]  start,
    input  logic [SIZE_W-1:0] size_code,
    output logic              misaligned
);

    localparam logic [EXT_W-1:0] LOW_ONES = (EXT_W'(1) << UNIT_LG2) - EXT_W'(1);

    logic [SIZE_W-1:0] smear;
    logic [EXT_W-1:0]  mask_bytes;

    // Mask of the size rounded up to a power of two, minus one
    always_comb begin
        smear = size_code - SIZE_W'(1);
        for (int i = SIZE_W - 2; i >= 0; i--) begin
            smear[i] = smear[i] | smear[i+1];
        end
        mask_bytes = (EXT_W'(smear) << UNIT_LG2) | LOW_ONES;
        misaligned = (size_code != '0) && ((start & mask_bytes) != '0);
    end

endmodule

// File: rtl/csdec_decoder.sv
module csdec_decoder
    import csdec_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned SIZE_W     = DEF_SIZE_W,
    parameter int unsigned UNIT_LG2   = DEF_UNIT_LG2,
    parameter int unsigned COARSE_W   = DEF_COARSE_W,
    parameter int unsigned COARSE_LG2 = DEF_COARSE_LG2,
    parameter int unsigned FINE_W     = DEF_FINE_W,
    parameter int unsigned FINE_LG2   = DEF_FINE_LG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [SIZE_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_cs,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic              cfg_err,
    output logic              overlap
);

    localparam int unsigned NUM_CS = 2;
    localparam int unsigned EXT_W  = ADDR_W + 3;

    typedef struct packed {
        logic                rsp_valid;
        logic [NUM_CS-1:0]   rsp_cs;
        logic                rsp_err;
        logic [ADDR_W-1:0]   rsp_offset;
        logic                cfg_err;
        logic                overlap;
    } state_t;

    state_t st_d, st_q;

    logic [SIZE_W-1:0]   size0, size1;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
    logic [EXT_W-1:0]    base1;
    logic                misaligned;

    logic [EXT_W-1:0]    reg_start [NUM_CS];
    logic [SIZE_W-1:0]   reg_size  [NUM_CS];
    logic [NUM_CS-1:0]   reg_hit;
    logic [ADDR_W-1:0]   reg_off   [NUM_CS];

    csdec_cfg_regs #(
        .SIZE_W   (SIZE_W),
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .SIZE0_RST(SIZE_W'(16))
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .size0 (size0),
        .size1 (size1),
        .coarse(coarse),
        .fine  (fine)
    );

    assign base1 = (EXT_W'(coarse) << COARSE_LG2) + (EXT_W'(fine) << FINE_LG2);

    assign reg_start[0] = '0;
    assign reg_start[1] = base1;
    assign reg_size[0]  = size0;
    assign reg_size[1]  = size1;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        csdec_region_match #(
            .ADDR_W  (ADDR_W),
            .EXT_W   (EXT_W),
            .SIZE_W  (SIZE_W),
            .UNIT_LG2(UNIT_LG2)
        ) u_match (
            .start    (reg_start[g]),
            .size_code(reg_size[g]),
            .addr     (req_addr),
            .hit      (reg_hit[g]),
            .offset   (reg_off[g])
        );
    end

    csdec_align_check #(
        .EXT_W   (EXT_W),
        .SIZE_W  (SIZE_W),
        .UNIT_LG2(UNIT_LG2)
    ) u_align (
        .start     (base1),
        .size_code (size1),
        .misaligned(misaligned)
    );

    logic [NUM_CS-1:0] usable;
    logic [EXT_W-1:0]  end0;

    always_comb begin
        st_d = st_q;

        // Device 1 is unusable while misaligned or after a sticky error
        usable    = reg_hit;
        usable[1] = reg_hit[1] & ~(misaligned | st_q.cfg_err);

        end0         = EXT_W'(size0) << UNIT_LG2;
        st_d.cfg_err = st_q.cfg_err | misaligned;
        st_d.overlap = (size0 != '0) && (size1 != '0) && (base1 < end0);

        st_d.rsp_valid  = req_valid;
        st_d.rsp_cs     = '0;
        st_d.rsp_err    = 1'b0;
        st_d.rsp_offset = '0;
        if (req_valid) begin
            // Lowest index wins
            for (int i = NUM_CS - 1; i >= 0; i--) begin
                if (usable[i]) begin
                    st_d.rsp_cs     = NUM_CS'(1) << i;
                    st_d.rsp_offset = reg_off[i];
                end
            end
            st_d.rsp_err = (usable == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_cs     = st_q.rsp_cs;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_offset = st_q.rsp_offset;
    assign cfg_err    = st_q.cfg_err;
    assign overlap    = st_q.overlap;

endmodule

// File: rtl/csdec_decoder_chk.sv
module csdec_decoder_chk #(
    parameter int unsigned ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [1:0]        rsp_cs,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] rsp_offset,
    input logic              cfg_err
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cs == 2'b00 && !rsp_err && rsp_offset == '0));

    assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    assert_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err != (rsp_cs != 2'b00)));

    assert_cfg_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_no_cs1_when_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cs[1] |-> !cfg_err);

    assert_cs0_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cs[0] |-> rsp_offset == $past(req_addr));

endmodule

bind csdec_decoder csdec_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_cs    (rsp_cs),
    .rsp_err   (rsp_err),
    .rsp_offset(rsp_offset),
    .cfg_err   (cfg_err)
);

// File: tb/test_csdec_decoder.sv
module test_csdec_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [9:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [29:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_cs;
    logic        rsp_err;
    logic [29:0] rsp_offset;
    logic        cfg_err;
    logic        overlap;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench model of the configuration
    longint m_sz0 = 16, m_sz1 = 0, m_coarse = 0, m_fine = 0;
    bit     m_sticky = 1'b0;

    localparam longint MB = 64'd1 << 20;

    always #5 clk = ~clk;

    csdec_decoder i_csdec_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_err(rsp_err),
        .rsp_offset(rsp_offset), .cfg_err(cfg_err), .overlap(overlap)
    );

    function automatic longint base1();
        return m_coarse * 128 * MB + m_fine * 32 * MB;
    endfunction

    function automatic bit misal();
        longint p = 1;
        if (m_sz1 == 0) return 1'b0;
        while (p < m_sz1) p = p * 2;
        return (base1() % (p * 2 * MB)) != 0;
    endfunction

    function automatic bit exp_overlap();
        return (m_sz0 != 0) && (m_sz1 != 0) && (base1() < m_sz0 * 2 * MB);
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [9:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data; req_valid = 1'b0;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (idx)
            2'd0: m_sz0 = data;
            2'd1: m_sz1 = data;
            2'd2: begin m_fine = data[1:0]; m_coarse = data[5:2]; end
            default: ;
        endcase
        if (misal()) m_sticky = 1'b1;
    endtask

    // One idle cycle, then compare status and idle response
    task automatic idle_status();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R7 overlap status", overlap, exp_overlap());
        check("R8 cfg_err status", cfg_err, m_sticky);
        check("R2 idle response", {rsp_valid, rsp_cs, rsp_err, rsp_offset}, 0);
    endtask

    task automatic req(input longint a, input string tag);
        longint s0b, b1, e1, exp_off;
        logic [1:0] exp_cs;
        logic exp_err;
        string rq;
        s0b = m_sz0 * 2 * MB;
        b1  = base1();
        e1  = b1 + m_sz1 * 2 * MB;
        if (m_sz0 != 0 && a < s0b) begin
            exp_cs = 2'b01; exp_err = 1'b0; exp_off = a; rq = "R3";
        end else if (m_sz1 != 0 && a >= b1 && a < e1 && !(m_sticky || misal())) begin
            exp_cs = 2'b10; exp_err = 1'b0; exp_off = a - b1; rq = "R4";
        end else begin
            exp_cs = 2'b00; exp_err = 1'b1; exp_off = 0; rq = "R5";
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a[29:0];
        @(posedge clk); #1;
        check({rq, " ", tag, " decode"}, {rsp_valid, rsp_cs, rsp_err, rsp_offset},
              {1'b1, exp_cs, exp_err, exp_off[29:0]});
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 1024; i++) begin
            longint a = longint'(i) * MB + ((i % 2 == 1) ? (MB - 1) : 0);
            req(a, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 cfg_err", cfg_err, 0);
        check("R1 overlap", overlap, 0);
        sweep("R1 R6 reset config");
        idle_status();

        // R4: device 1 at 512 MB, 256 MB long
        wr(2'd1, 10'h080);
        wr(2'd2, 10'd16);
        idle_status();
        sweep("R4 base 0x20000000");

        // R9: write takes effect on the very next request
        wr(2'd1, 10'h000);
        req(64'h2000_0000, "R9 R6 disable next cycle");
        wr(2'd1, 10'h080);
        req(64'h2000_0000, "R9 enable next cycle");
        req(64'h2FFF_FFFF, "R9 last byte");
        req(64'h3000_0000, "R9 one past end");

        // R9: index 3 changes nothing
        wr(2'd3, 10'h3FF);
        idle_status();
        sweep("R9 spare index");

        // R6: device 0 disabled
        wr(2'd0, 10'h000);
        idle_status();
        sweep("R6 cs0 off");

        // R7: device 1 hidden under device 0
        wr(2'd0, 10'h100);
        wr(2'd2, 10'd8);
        idle_status();
        sweep("R7 full overlap");

        // R7: partial overlap, device 1 from 0 for 128 MB
        wr(2'd0, 10'h010);
        wr(2'd1, 10'h040);
        wr(2'd2, 10'd0);
        idle_status();
        sweep("R7 partial overlap");

        // R8: misaligned base 160 MB for 128 MB device
        wr(2'd2, 10'd5);
        idle_status();
        sweep("R8 misaligned");
        // R8: realigned, error stays
        wr(2'd2, 10'd4);
        idle_status();
        sweep("R8 sticky");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule